// File: doc/BRIEF.md
# Tile Fetch Bus and Half-Row Sequencer

This block times the shared 24-bit pixel bus that a tile renderer uses to fetch fix-layer and sprite graphics. It runs on a fast clock and advances one step on each cycle where `step_en` is high. Each step stands for half a cycle of the rendering clock. A window of 32 steps (16 rendering clocks) is cut into six phases. In turn these carry the fix palette, the fix tile address, an idle gap, the sprite palette with its X position, the sprite tile address, and a second idle gap. Two windows make one tile row. The first window fetches the first half of each row and the second window fetches the second half.

The block also produces the two quarter-row select bits that external ROM address logic appends, one for fix data and one for sprite data. It drives two pixel-latch strobes as well. The fix strobe and its quarter select are timed from the start of the row. The sprite strobe and its quarter select run half a window later. A `line_go` pulse restarts the row timing, so the fix strobe always comes first on a new line.

Top module: `tile_fetch_seq`

## Requirements
- R1: In the fix-address phase (tag 1), bus[23:16] is zero. bus[15:5] is `fix_code`, bus[4] is the half bit and bus[3:0] is `fix_row`.
- R2: In the sprite-address phase (tag 4), bus[23:6] is `spr_code`, bus[5] is the half bit and bus[4:0] is `spr_row`.
- R3: In the fix-palette phase (tag 0), bus[19:16] is `fix_pal` and every other bus bit is zero.
- R4: In the sprite-palette phase (tag 3), bus[23:16] is `spr_pal`, bus[15:8] is `spr_x` and bus[7:0] is zero.
- R5: Steps 0-31 of a window map to phases in this order: tag 0 for 3 steps, tag 1 for 10, tag 2 for 3, tag 3 for 3, tag 4 for 10, tag 5 for 3. During tags 2 and 5 the bus is all zero.
- R6: The half bit is 1 during row steps 0-31 (first window) and 0 during row steps 32-63 (second window).
- R7: `fix_qsel` is 0 for row steps 0-15 and then toggles every 16 steps. That is every 2 fix pixels, at 8 steps per fix pixel.
- R8: `spr_qsel` is 1 for row steps 0-15 and then toggles every 16 steps. That is every 4 sprite pixels, at 4 steps per pixel, offset by 16 steps from the fix lane.
- R9: `fix_stb` is high on window steps 0-1 and `spr_stb` is high on window steps 16-17. The two strobes are never high together.
- R10: A `line_go` pulse sets the row step to 0 on the next cycle, whatever the state of `step_en`. The fix strobe is then high, and the sprite strobe follows 16 steps later.
- R11: With `step_en` low and `line_go` low, the row step holds, so tag, selects and strobes stay unchanged.
- R12: Reset (synchronous, active high) sets the row step to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance one half-clock step |
| line_go | input | 1 | Restart row timing at step 0 |
| fix_code | input | 11 | Fix tile code |
| fix_row | input | 4 | Fix pixel row within tile |
| fix_pal | input | 4 | Fix tile palette |
| spr_code | input | 18 | Sprite tile code |
| spr_row | input | 5 | Sprite pixel row within tile |
| spr_pal | input | 8 | Sprite palette |
| spr_x | input | 8 | Sprite X position |
| bus | output | 24 | Shared pixel-bus value |
| phase_tag | output | 3 | Current bus phase (0..5) |
| fix_qsel | output | 1 | Fix quarter-row select |
| spr_qsel | output | 1 | Sprite quarter-row select |
| fix_stb | output | 1 | Fix pixel latch strobe |
| spr_stb | output | 1 | Sprite pixel latch strobe |

## Verification
The bench looks hardest at the phase boundaries, that is window steps 2/3, 12/13, 15/16, 18/19 and 28/29. A boundary off by one step would hand a ROM address to a palette latch for a step. It also checks the half bit at the row midpoint; a design that got this wrong would fetch the same half of a row twice. Two cases check the sprite lane offset. A sprite lane with no offset would move its quarter select to the fix timing. A `line_go` that collides with `step_en`, or that arrives mid-window, would leave the sprite strobe ahead of the fix strobe. Held cycles with `step_en` low catch a counter that runs freely.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int BUS_W      = 24;
    localparam int FIX_CODE_W = 11;
    localparam int FIX_ROW_W  = 4;
    localparam int FIX_PAL_W  = 4;
    localparam int SPR_CODE_W = 18;
    localparam int SPR_ROW_W  = 5;
    localparam int SPR_PAL_W  = 8;
    localparam int XPOS_W     = 8;

    typedef enum logic [2:0] {
        PH_FIX_PAL = 3'd0,
        PH_FIX_ADR = 3'd1,
        PH_GAP_A   = 3'd2,
        PH_SPR_PAL = 3'd3,
        PH_SPR_ADR = 3'd4,
        PH_GAP_B   = 3'd5
    } phase_e;

    typedef struct packed {
        logic [FIX_CODE_W-1:0] code;
        logic [FIX_ROW_W-1:0]  row;
        logic [FIX_PAL_W-1:0]  pal;
    } fix_attr_t;

    typedef struct packed {
        logic [SPR_CODE_W-1:0] code;
        logic [SPR_ROW_W-1:0]  row;
        logic [SPR_PAL_W-1:0]  pal;
        logic [XPOS_W-1:0]     xpos;
    } spr_attr_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_FIX_PAL: next_phase = PH_FIX_ADR;
            PH_FIX_ADR: next_phase = PH_GAP_A;
            PH_GAP_A:   next_phase = PH_SPR_PAL;
            PH_SPR_PAL: next_phase = PH_SPR_ADR;
            PH_SPR_ADR: next_phase = PH_GAP_B;
            default:    next_phase = PH_FIX_PAL;
        endcase
    endfunction

endpackage

// File: rtl/tfs_timebase.sv
module tfs_timebase #(
    parameter int WINDOW = 32,
    parameter int ROW    = 2 * WINDOW,
    parameter int CW     = $clog2(ROW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          line_go,
    output logic [CW-1:0] row_step,
    output logic [CW-1:0] win_step,
    output logic          first_win
);
    localparam logic [CW-1:0] LAST = CW'(ROW - 1);
    localparam logic [CW-1:0] WINV = CW'(WINDOW);

    logic [CW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (line_go) begin
            step_q <= '0;
        end else if (step_en) begin
            step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
        end
    end

    always_comb begin
        row_step  = step_q;
        first_win = (step_q < WINV);
        win_step  = first_win ? step_q : step_q - WINV;
    end
endmodule

// File: rtl/tfs_phase_dec.sv
module tfs_phase_dec
    import tfs_pkg::*;
#(
    parameter int SHORT_T = 3,
    parameter int LONG_T  = 10,
    parameter int CW      = 6
) (
    input  logic [CW-1:0] win_step,
    output phase_e        phase
);
    localparam int E0 = SHORT_T;
    localparam int E1 = E0 + LONG_T;
    localparam int E2 = E1 + SHORT_T;
    localparam int E3 = E2 + SHORT_T;
    localparam int E4 = E3 + LONG_T;

    localparam logic [CW-1:0] B0 = CW'(E0);
    localparam logic [CW-1:0] B1 = CW'(E1);
    localparam logic [CW-1:0] B2 = CW'(E2);
    localparam logic [CW-1:0] B3 = CW'(E3);
    localparam logic [CW-1:0] B4 = CW'(E4);

    always_comb begin
        if (win_step < B0)      phase = PH_FIX_PAL;
        else if (win_step < B1) phase = PH_FIX_ADR;
        else if (win_step < B2) phase = PH_GAP_A;
        else if (win_step < B3) phase = PH_SPR_PAL;
        else if (win_step < B4) phase = PH_SPR_ADR;
        else                    phase = PH_GAP_B;
    end
endmodule

// File: rtl/tfs_lane.sv
module tfs_lane #(
    parameter int WINDOW = 32,
    parameter int ROW    = 64,
    parameter int OFFSET = 0,
    parameter int STB_T  = 2,
    parameter int CW     = 6
) (
    input  logic [CW-1:0] row_step,
    output logic          qsel,
    output logic          stb
);
    localparam int            QTR  = ROW / 4;
    localparam logic [CW:0]   ROWV = (CW+1)'(ROW);
    localparam logic [CW:0]   ADDV = (CW+1)'(ROW - OFFSET);
    localparam logic [CW:0]   QV   = (CW+1)'(QTR);
    localparam logic [CW:0]   WV   = (CW+1)'(WINDOW);
    localparam logic [CW:0]   SV   = (CW+1)'(STB_T);

    logic [CW:0] sum;
    logic [CW:0] rel;
    logic [CW:0] rel_w;
    logic [CW:0] quarter;

    always_comb begin
        sum     = {1'b0, row_step} + ADDV;
        rel     = (sum >= ROWV) ? sum - ROWV : sum;
        rel_w   = (rel >= WV) ? rel - WV : rel;
        quarter = rel / QV;
        qsel    = quarter[0];
        stb     = (rel_w < SV);
    end
endmodule

// File: rtl/tfs_bus_mux.sv
module tfs_bus_mux
    import tfs_pkg::*;
(
    input  phase_e             phase,
    input  logic               half,
    input  fix_attr_t          fix,
    input  spr_attr_t          spr,
    output logic [BUS_W-1:0]   bus
);
    localparam int FIX_ADR_W = FIX_CODE_W + 1 + FIX_ROW_W;
    localparam int FIX_PAD_W = BUS_W - FIX_ADR_W;
    localparam int FP_LO_W   = 16;
    localparam int FP_HI_W   = BUS_W - FP_LO_W - FIX_PAL_W;
    localparam int SP_LO_W   = BUS_W - SPR_PAL_W - XPOS_W;

    always_comb begin
        case (phase)
            PH_FIX_PAL: bus = {{FP_HI_W{1'b0}}, fix.pal, {FP_LO_W{1'b0}}};
            PH_FIX_ADR: bus = {{FIX_PAD_W{1'b0}}, fix.code, half, fix.row};
            PH_SPR_PAL: bus = {spr.pal, spr.xpos, {SP_LO_W{1'b0}}};
            PH_SPR_ADR: bus = {spr.code, half, spr.row};
            default:    bus = '0;
        endcase
    end
endmodule

// File: rtl/tile_fetch_seq.sv
module tile_fetch_seq
    import tfs_pkg::*;
#(
    parameter int SHORT_T = 3,
    parameter int LONG_T  = 10,
    parameter int STB_T   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    input  logic                  line_go,
    input  logic [10:0]           fix_code,
    input  logic [3:0]            fix_row,
    input  logic [3:0]            fix_pal,
    input  logic [17:0]           spr_code,
    input  logic [4:0]            spr_row,
    input  logic [7:0]            spr_pal,
    input  logic [7:0]            spr_x,
    output logic [23:0]           bus,
    output logic [2:0]            phase_tag,
    output logic                  fix_qsel,
    output logic                  spr_qsel,
    output logic                  fix_stb,
    output logic                  spr_stb
);
    localparam int WINDOW = 4 * SHORT_T + 2 * LONG_T;
    localparam int ROW    = 2 * WINDOW;
    localparam int CW     = $clog2(ROW);
    localparam int LANES  = 2;

    logic [CW-1:0]    row_step;
    logic [CW-1:0]    win_step;
    logic             first_win;
    phase_e           phase;
    fix_attr_t        fix;
    spr_attr_t        spr;
    logic [LANES-1:0] lane_q;
    logic [LANES-1:0] lane_s;

    assign fix = '{code: fix_code, row: fix_row, pal: fix_pal};
    assign spr = '{code: spr_code, row: spr_row, pal: spr_pal, xpos: spr_x};

    tfs_timebase #(.WINDOW(WINDOW), .ROW(ROW), .CW(CW)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .line_go  (line_go),
        .row_step (row_step),
        .win_step (win_step),
        .first_win(first_win)
    );

    tfs_phase_dec #(.SHORT_T(SHORT_T), .LONG_T(LONG_T), .CW(CW)) u_pd (
        .win_step(win_step),
        .phase   (phase)
    );

    // lane 0 times fix data, lane 1 times sprite data half a window later
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tfs_lane #(
            .WINDOW(WINDOW),
            .ROW   (ROW),
            .OFFSET(g * (WINDOW / 2)),
            .STB_T (STB_T),
            .CW    (CW)
        ) u_lane (
            .row_step(row_step),
            .qsel    (lane_q[g]),
            .stb     (lane_s[g])
        );
    end

    tfs_bus_mux u_mux (
        .phase(phase),
        .half (first_win),
        .fix  (fix),
        .spr  (spr),
        .bus  (bus)
    );

    assign phase_tag = phase;
    assign fix_qsel  = lane_q[0];
    assign spr_qsel  = lane_q[1];
    assign fix_stb   = lane_s[0];
    assign spr_stb   = lane_s[1];
endmodule

// File: rtl/tile_fetch_seq_chk.sv
module tile_fetch_seq_chk
    import tfs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        step_en,
    input logic        line_go,
    input logic [3:0]  fix_pal,
    input logic [7:0]  spr_pal,
    input logic [7:0]  spr_x,
    input logic [23:0] bus,
    input logic [2:0]  phase_tag,
    input logic        fix_qsel,
    input logic        spr_qsel,
    input logic        fix_stb,
    input logic        spr_stb
);
    p_fix_hi_zero_r1: assert property (@(posedge clk) disable iff (rst)
        phase_tag == 3'd1 |-> bus[23:16] == 8'h00);

    p_fix_pal_field_r3: assert property (@(posedge clk) disable iff (rst)
        phase_tag == 3'd0 |-> (bus[23:20] == 4'h0 && bus[19:16] == fix_pal && bus[15:0] == 16'h0));

    p_spr_pal_field_r4: assert property (@(posedge clk) disable iff (rst)
        phase_tag == 3'd3 |-> (bus[23:16] == spr_pal && bus[15:8] == spr_x && bus[7:0] == 8'h00));

    p_gap_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_tag == 3'd2 || phase_tag == 3'd5) |-> bus == 24'h0);

    p_phase_order_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !line_go) |=>
            (phase_tag == $past(phase_tag) ||
             phase_tag == 3'(next_phase(phase_e'($past(phase_tag))))));

    p_stb_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(fix_stb && spr_stb));

    p_line_restart_r10: assert property (@(posedge clk) disable iff (rst)
        line_go |=> (fix_stb && !spr_stb && phase_tag == 3'd0));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !line_go) |=>
            ($stable(phase_tag) && $stable(fix_qsel) && $stable(spr_qsel) &&
             $stable(fix_stb) && $stable(spr_stb)));
endmodule

bind tile_fetch_seq tile_fetch_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .line_go  (line_go),
    .fix_pal  (fix_pal),
    .spr_pal  (spr_pal),
    .spr_x    (spr_x),
    .bus      (bus),
    .phase_tag(phase_tag),
    .fix_qsel (fix_qsel),
    .spr_qsel (spr_qsel),
    .fix_stb  (fix_stb),
    .spr_stb  (spr_stb)
);

// File: tb/tile_fetch_seq_bench.sv
module tile_fetch_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        line_go = 1'b0;
    logic [10:0] fix_code = '0;
    logic [3:0]  fix_row = '0;
    logic [3:0]  fix_pal = '0;
    logic [17:0] spr_code = '0;
    logic [4:0]  spr_row = '0;
    logic [7:0]  spr_pal = '0;
    logic [7:0]  spr_x = '0;
    logic [23:0] bus;
    logic [2:0]  phase_tag;
    logic        fix_qsel, spr_qsel, fix_stb, spr_stb;

    int n_chk = 0;
    int n_fail = 0;
    int t = 0;
    bit done = 0;
    bit was_go = 0;
    bit was_hold = 0;
    logic [2:0] prev_tag = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tile_fetch_seq u_tile_fetch_seq (
        .clk(clk), .rst(rst), .step_en(step_en), .line_go(line_go),
        .fix_code(fix_code), .fix_row(fix_row), .fix_pal(fix_pal),
        .spr_code(spr_code), .spr_row(spr_row), .spr_pal(spr_pal), .spr_x(spr_x),
        .bus(bus), .phase_tag(phase_tag), .fix_qsel(fix_qsel), .spr_qsel(spr_qsel),
        .fix_stb(fix_stb), .spr_stb(spr_stb)
    );

    // behavioural reference: row step as a plain integer
    always @(posedge clk) begin
        if (rst || line_go) t = 0;
        else if (step_en) t = (t + 1) % 64;
    end

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
        end
    endtask

    task automatic check_all();
        int w;
        int ph;
        logic half;
        logic [23:0] eb;
        w = t % 32;
        half = (t < 32);
        if (w < 3) ph = 0;
        else if (w < 13) ph = 1;
        else if (w < 16) ph = 2;
        else if (w < 19) ph = 3;
        else if (w < 29) ph = 4;
        else ph = 5;
        chk("R5 tag", 24'(phase_tag), 24'(ph));
        case (ph)
            0: begin eb = {4'h0, fix_pal, 16'h0};             chk("R3 bus", bus, eb); end
            1: begin eb = {8'h0, fix_code, half, fix_row};    chk("R1 bus", bus, eb);
                     chk("R6 fix half", 24'(bus[4]), 24'(half)); end
            3: begin eb = {spr_pal, spr_x, 8'h0};             chk("R4 bus", bus, eb); end
            4: begin eb = {spr_code, half, spr_row};          chk("R2 bus", bus, eb);
                     chk("R6 spr half", 24'(bus[5]), 24'(half)); end
            default: chk("R5 gap bus", bus, 24'h0);
        endcase
        chk("R7 fix_qsel", 24'(fix_qsel), 24'((t / 16) % 2));
        chk("R8 spr_qsel", 24'(spr_qsel), 24'((((t + 48) % 64) / 16) % 2));
        chk("R9 fix_stb", 24'(fix_stb), 24'(w < 2));
        chk("R9 spr_stb", 24'(spr_stb), 24'(w == 16 || w == 17));
        if (was_go) chk("R10 strobes after line_go", {22'h0, fix_stb, spr_stb}, 24'h2);
        if (was_hold) chk("R11 hold tag", 24'(phase_tag), 24'(prev_tag));
    endtask

    task automatic new_attrs(input bit ones);
        if (ones) begin
            fix_code = '1; fix_row = '1; fix_pal = '1;
            spr_code = '1; spr_row = '1; spr_pal = '1; spr_x = '1;
        end else begin
            fix_code = 11'($urandom); fix_row = 4'($urandom); fix_pal = 4'($urandom);
            spr_code = 18'($urandom); spr_row = 5'($urandom);
            spr_pal = 8'($urandom); spr_x = 8'($urandom);
        end
    endtask

    task automatic cycle(input int go_rate, input int hold_rate, input int attr_rate, input bit ones);
        @(negedge clk);
        check_all();
        prev_tag = phase_tag;
        was_go = line_go;
        line_go = (go_rate > 0) && ($urandom % go_rate == 0);
        step_en = !((hold_rate > 0) && ($urandom % hold_rate == 0));
        was_hold = !line_go && !step_en;
        if ($urandom % attr_rate == 0) new_attrs(ones);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset tag", 24'(phase_tag), 24'h0);
        chk("R12 reset strobes", {22'h0, fix_stb, spr_stb}, 24'h2);
        chk("R12 reset qsel", {22'h0, fix_qsel, spr_qsel}, 24'h1);
        rst = 1'b0;
        step_en = 1'b1;
        new_attrs(0);
        for (int i = 0; i < 300; i++) cycle(0, 0, 7, 0);
        new_attrs(1);
        for (int i = 0; i < 130; i++) cycle(0, 0, 1000, 1);
        for (int i = 0; i < 400; i++) cycle(0, 3, 5, 0);
        for (int i = 0; i < 600; i++) cycle(23, 4, 9, 0);
        // line_go together with step_en, mid-window
        for (int i = 0; i < 20; i++) cycle(0, 0, 50, 0);
        @(negedge clk);
        check_all();
        line_go = 1'b1; step_en = 1'b1;
        @(negedge clk);
        was_go = 1'b1; was_hold = 1'b0;
        line_go = 1'b0;
        check_all();
        was_go = 1'b0;
        for (int i = 0; i < 40; i++) cycle(0, 0, 50, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule